// File: doc/BRIEF.md
# Residue-Domain Max-Pooling Unit

This block pools a window of signed integers that are held in residue form over the moduli 2, 3, 5 and 7. The product of the moduli is 210, so the signed range is -105 to 104. A negative value X is stored per modulus as (m - |X| mod m) mod m. For example, -20 is stored as r2=0, r3=1, r5=0, r7=1. A residue code gives no direct sign and no direct ordering. For that reason each incoming value is turned into mixed-radix digits with the weights 1, 3, 15 and 105. The digit of weight 105 belongs to modulus 2. It is 1 exactly when the value is negative. The other three digits order values that share a sign.

The conversion needs one step per digit. It runs as a three-stage pipeline, so a new value can enter on every clock. A value is accepted when `in_valid` is high. `in_last` marks the final value of a window. After the last converted value of a window, the stage that tracks the running maximum loads the window's largest value into the output register and raises `out_valid` for one cycle. The running maximum is then cleared for the next window. The output is the residue tuple of the winner, as it was received.

Top module: `rns_maxpool`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of a window, `out_valid` is 0 and no earlier value takes part in the next window's result.
- R2: Residue coding: r2 in 0..1, r3 in 0..2, r5 in 0..4 and r7 in 0..6. A non-negative value v is stored as v mod m. A negative value is stored as (v + 210) mod m. The output tuple is always a legal residue tuple.
- R3: Every converted value yields mixed-radix digits below 3, 5 and 7 for the weights 1, 3 and 15.
- R4: Any value in 0..104 beats any value in -105..-1. For example, a window holding 104, -105, 0 and -1 yields 104.
- R5: Among values of the same sign, the larger signed value wins. For example, -1 beats -50 and -105.
- R6: `out_valid` is high exactly in the fourth clock edge after the edge that accepts an input with `in_valid` and `in_last` both high, counting that accepting edge as the first. It is high at no other time.
- R7: Windows may follow each other with no idle cycles. Each window's result depends only on that window's own values. A one-element window yields its sole element.
- R8: Cycles with `in_valid` low are ignored. Their residues and their `in_last` affect neither the result nor `out_valid`.
- R9: The output tuple keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_last | input | 1 | Input value closes the window |
| in_r2 | input | 1 | Input residue mod 2 |
| in_r3 | input | 2 | Input residue mod 3 |
| in_r5 | input | 3 | Input residue mod 5 |
| in_r7 | input | 3 | Input residue mod 7 |
| out_valid | output | 1 | Window maximum present (one cycle) |
| out_r2 | output | 1 | Result residue mod 2 |
| out_r3 | output | 2 | Result residue mod 3 |
| out_r5 | output | 3 | Result residue mod 5 |
| out_r7 | output | 3 | Result residue mod 7 |

## Verification
The assertions check four things on every cycle. They check the fixed four-edge link between an accepted window-closing input and `out_valid`, in both directions. They check that the mixed-radix digits stay in range, that the output tuple stays legal, and that it holds still while no result is flagged. Only the bench scenarios can show that the chosen value is actually the maximum. Those scenarios compare against a binary model and cover the sign split at -1/0, the extremes -105 and 104, repeated equal values, back-to-back and single-element windows, ignored idle cycles, and a reset that cuts a window short.

// File: rtl/rns_maxpool.sv
module rns_maxpool (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic [0:0] in_r2,
  input  logic [1:0] in_r3,
  input  logic [2:0] in_r5,
  input  logic [2:0] in_r7,
  output logic       out_valid,
  output logic [0:0] out_r2,
  output logic [1:0] out_r3,
  output logic [2:0] out_r5,
  output logic [2:0] out_r7
);

  localparam int TW = 1 + 2 + 3 + 3;
  localparam int KW = 1 + 3 + 3 + 2;

  function automatic logic [2:0] mod5(input int v);
    int t;
    t = v % 5;
    return t[2:0];
  endfunction

  function automatic logic [2:0] mod7(input int v);
    int t;
    t = v % 7;
    return t[2:0];
  endfunction

  // stage 1: digit of weight 1, rest scaled by 1/3
  logic          v1, l1, x2_1;
  logic [1:0]    a1_1;
  logic [2:0]    x5_1, x7_1;
  logic [TW-1:0] t1;

  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
    l1   <= in_last;
    t1   <= {in_r2, in_r3, in_r5, in_r7};
    a1_1 <= in_r3;
    x5_1 <= mod5((int'(in_r5) + 5 - int'(in_r3)) * 2);
    x7_1 <= mod7((int'(in_r7) + 7 - int'(in_r3)) * 5);
    x2_1 <= in_r2[0] ^ in_r3[0];
  end

  // stage 2: digit of weight 3, rest scaled by 1/5
  logic          v2, l2, x2_2;
  logic [1:0]    a1_2;
  logic [2:0]    a2_2, x7_2;
  logic [TW-1:0] t2;

  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    l2   <= l1;
    t2   <= t1;
    a1_2 <= a1_1;
    a2_2 <= x5_1;
    x7_2 <= mod7((int'(x7_1) + 7 - int'(x5_1)) * 3);
    x2_2 <= x2_1 ^ x5_1[0];
  end

  // stage 3: digits of weight 15 and 105 (sign)
  logic          v3, l3, a4_3;
  logic [1:0]    a1_3;
  logic [2:0]    a2_3, a3_3;
  logic [TW-1:0] t3;

  always_ff @(posedge clk) begin
    if (!rst_n) v3 <= 1'b0;
    else        v3 <= v2;
    l3   <= l2;
    t3   <= t2;
    a1_3 <= a1_2;
    a2_3 <= a2_2;
    a3_3 <= x7_2;
    a4_3 <= x2_2 ^ x7_2[0];
  end

  // running maximum; key orders by sign then digits
  logic [KW-1:0] key3, best_key, win_key;
  logic [TW-1:0] best_t, win_t, out_t;
  logic          have, take;

  assign key3    = {~a4_3, a3_3, a2_3, a1_3};
  assign take    = !have || (key3 > best_key);
  assign win_key = take ? key3 : best_key;
  assign win_t   = take ? t3 : best_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have      <= 1'b0;
      out_valid <= 1'b0;
      out_t     <= '0;
      best_key  <= '0;
      best_t    <= '0;
    end else begin
      out_valid <= v3 && l3;
      if (v3) begin
        if (l3) begin
          have  <= 1'b0;
          out_t <= win_t;
        end else begin
          have     <= 1'b1;
          best_key <= win_key;
          best_t   <= win_t;
        end
      end
    end
  end

  assign out_r2 = out_t[8];
  assign out_r3 = out_t[7:6];
  assign out_r5 = out_t[5:3];
  assign out_r7 = out_t[2:0];

endmodule

// File: rtl/rns_maxpool_chk.sv
module rns_maxpool_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_last,
  input logic       out_valid,
  input logic [0:0] out_r2,
  input logic [1:0] out_r3,
  input logic [2:0] out_r5,
  input logic [2:0] out_r7,
  input logic       v3,
  input logic [1:0] a1_3,
  input logic [2:0] a2_3,
  input logic [2:0] a3_3
);

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last, 4)); // R6
  AST_LAST_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_last, 4) |-> out_valid); // R6
  AST_DIGITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> (a1_3 < 2'd3 && a2_3 < 3'd5 && a3_3 < 3'd7)); // R3
  AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_r3 < 2'd3 && out_r5 < 3'd5 && out_r7 < 3'd7); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({out_r2, out_r3, out_r5, out_r7})); // R9

endmodule

bind rns_maxpool rns_maxpool_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .out_valid(out_valid), .out_r2(out_r2), .out_r3(out_r3), .out_r5(out_r5),
  .out_r7(out_r7), .v3(v3), .a1_3(a1_3), .a2_3(a2_3), .a3_3(a3_3)
);

// File: tb/rns_maxpool_tb.sv
module rns_maxpool_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int TV [NV] = '{104, -105, 0, -1,  -1, -105, -50,  -105,
                             3, 77, 2,  -20, -20,  -1, 0,  20};
  localparam bit TL [NV] = '{0, 0, 0, 1,  0, 0, 1,  1,  0, 0, 1,  0, 1,  0, 1,  1};
  localparam string TT [NV] = '{"R4", "R4", "R4", "R4", "R5", "R5", "R5", "R7",
                                "R5", "R5", "R5", "R5", "R5", "R4", "R4", "R7"};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [0:0] in_r2 = '0;
  logic [1:0] in_r3 = '0;
  logic [2:0] in_r5 = '0, in_r7 = '0;
  logic out_valid;
  logic [0:0] out_r2;
  logic [1:0] out_r3;
  logic [2:0] out_r5, out_r7;

  int tests = 0, fails = 0, cyc = 0;
  int cur_max = 0;
  bit have = 0;
  int exp_v[$], exp_c[$];
  string exp_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rns_maxpool dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_r2(in_r2), .in_r3(in_r3), .in_r5(in_r5), .in_r7(in_r7), .out_valid(out_valid),
    .out_r2(out_r2), .out_r3(out_r3), .out_r5(out_r5), .out_r7(out_r7));

  function automatic int enc(int v);
    return (v < 0) ? v + 210 : v;
  endfunction

  function automatic int dec(int r2, int r3, int r5, int r7);
    for (int u = 0; u < 210; u++)
      if (u % 2 == r2 && u % 3 == r3 && u % 5 == r5 && u % 7 == r7)
        return (u >= 105) ? u - 210 : u;
    return 999;
  endfunction

  task automatic put(int v, bit vld, bit last);
    int u;
    u = enc(v);
    in_valid = vld; in_last = last;
    in_r2 = 1'(u % 2); in_r3 = 2'(u % 3); in_r5 = 3'(u % 5); in_r7 = 3'(u % 7);
  endtask

  task automatic send(int v, bit last, string tag);
    @(negedge clk);
    put(v, 1'b1, last);
    if (!have || v > cur_max) cur_max = v;
    have = 1;
    if (last) begin
      exp_v.push_back(cur_max); exp_c.push_back(cyc + 4); exp_t.push_back(tag);
      have = 0;
    end
  endtask

  task automatic idle(int n, int garbage);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      put(garbage, 1'b0, 1'b1);
    end
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_v.size() == 0) begin
        check(0, "R8 unexpected out_valid", 1, 0);
      end else begin
        int ev, ec, act;
        string et;
        ev = exp_v.pop_front(); ec = exp_c.pop_front(); et = exp_t.pop_front();
        act = dec(int'(out_r2), int'(out_r3), int'(out_r5), int'(out_r7));
        check(act == ev, {et, " window maximum"}, act, ev);
        check(cyc == ec, "R6 result cycle", cyc, ec);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    put(0, 0, 0);
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);

    // table walked back to back (R4 R5 R7)
    for (int i = 0; i < NV; i++) send(TV[i], TL[i], TT[i]);
    idle(6, 0);

    // idle cycles carrying a large value and last flag are ignored (R8)
    send(-9, 0, "R8");
    idle(3, 104);
    send(-4, 1, "R8");
    idle(6, 104);

    // reset mid-window discards partial maximum (R1)
    send(104, 0, "R1");
    send(50, 0, "R1");
    idle(5, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (6) @(negedge clk);
    have = 0;
    rst_n = 1'b1;
    check(out_valid == 1'b0, "R1 after mid-window reset", int'(out_valid), 0);
    send(-7, 0, "R1");
    send(-3, 1, "R1");
    idle(6, 0);

    // random windows against binary model (R4 R5 R7)
    for (int w = 0; w < 40; w++) begin
      int len;
      len = 1 + int'($urandom_range(5));
      for (int k = 0; k < len; k++)
        send(int'($urandom_range(209)) - 105, k == len - 1, "R5");
    end
    idle(10, 0);
    check(exp_v.size() == 0, "R6 all results delivered", exp_v.size(), 0);
    check(out_valid == 1'b0, "R6 single-cycle result", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule